// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for one access. Each request carries an access kind and a user/privileged flag. When translation is needed, the block reads page-table descriptors one word at a time through a simple memory port. It then answers with one of two outcomes:

- a physical address, a read/write/execute grant and a flag that marks a 4 MB superpage; or
- a non-zero fault code. The fault code and the faulting address are also latched in two fault registers, and the answer raises an instruction-abort or data-abort cause.

Two paths skip the walk entirely:

- **Translation off.** When translation is switched off, the answer is the address unchanged, with every permission granted.
- **Privileged low half.** With translation on, a privileged access below 2 GB is answered directly as an I/O window, with the top address bit forced to one.

Only one walk is in flight at a time. The block is a four-state machine:

- `ST_IDLE` accepts a request. It moves to `ST_RESP` on a bypass and to `ST_L1` on a walk.
- `ST_L1` fetches the first-level descriptor. It moves to `ST_L2` for a present table pointer; otherwise it moves to `ST_RESP` with a superpage result or a fault.
- `ST_L2` fetches the second-level descriptor and always moves to `ST_RESP`.
- `ST_RESP` presents the answer for one cycle and returns to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: With `cfg_xlate_on` low, the answer is `rsp_pa` equal to the VA, `rsp_perm` = 3'b111 and `rsp_fcode` = 0, with no descriptor read.
- R2: With `cfg_xlate_on` high, a privileged request (`req_user`=0) whose VA bit 31 is 0 makes no descriptor read. It answers `rsp_pa` = VA with bit 31 set, `rsp_perm` = 3'b111 and `rsp_fcode` = 0.
- R3: A walk first reads the word at `{cfg_tbase, VA[31:22], 2'b00}`. `mem_req` and `mem_addr` stay steady until `mem_rvalid`.
- R4: Descriptor fields are: type in bits [1:0] and present flag in bit 2. A first-level descriptor of type 3 is a superpage. If it is present, the answer is PA = `{desc[31:22], VA[21:0]}` with `rsp_super`=1. If it is not present, the fault code is 8'h0B.
- R5: A first-level descriptor of type 0 that is not present faults with 8'h05. If it is present, the second read goes to `{desc[31:12], VA[21:12], 2'b00}`.
- R6: A second-level descriptor that is not present faults with 8'h08. A present descriptor of type 0 gives PA = `{desc[31:12], VA[11:0]}` with `rsp_super`=0.
- R7: A first-level type of 1 or 2 faults with 8'h0C. A present second-level descriptor of non-zero type faults with 8'h0D.
- R8: The grant comes from the final descriptor: read from bit 8, write from bit 7, execute from bit 6. It is reported as `rsp_perm` = {exec, write, read}.
  - Access kinds are `req_acc` 0 = read, 1 = write, 2 = execute.
  - A user access whose kind is not granted faults with 8'h11 (read), 8'h12 (write) or 8'h13 (execute).
  - A privileged access never takes a permission fault.
  - On any fault, `rsp_pa`, `rsp_perm` and `rsp_super` are zero.
- R9: On a fault, `flt_status` takes the fault code and `flt_addr` takes the VA, both visible while the answer is presented. A successful answer leaves both unchanged. Both reset to 0.
- R10: With a non-zero fault code, an execute access raises `abort_instr` and any other access raises `abort_data`, only during the answer cycle. The two are never high together.
- R11: `req_ready` is high only in `ST_IDLE`. It is low from the cycle after acceptance until the cycle after the single-cycle `rsp_valid`. After reset, `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_xlate_on | input | 1 | Translation enable |
| cfg_tbase | input | 20 | First-level table base, bits [31:12] |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 = user access, 0 = privileged |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor data |
| rsp_valid | output | 1 | Answer present (one cycle) |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 3 | Grant {exec, write, read} |
| rsp_super | output | 1 | Answer is a 4 MB superpage |
| rsp_fcode | output | 8 | Fault code, 0 on success |
| abort_instr | output | 1 | Instruction-abort cause |
| abort_data | output | 1 | Data-abort cause |
| flt_status | output | 8 | Last fault code |
| flt_addr | output | 32 | Last faulting VA |

## Verification
The answer cycle is where two functions meet: the answer is presented, and the fault registers and abort cause update at the same moment. A late capture or a stale value there would go unseen in either function checked alone.

The bench provokes this cycle with randomly hashed descriptor memory and random memory latency, so faults at each level and each permission kind arrive mixed among successes. At every `rsp_valid` it samples the answer, both fault registers and both abort lines together. It compares them with a bench model that tracks what the fault registers should hold, including that they stay unchanged across successes.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int FCODE_W = 8;

    localparam logic [FCODE_W-1:0] FC_OK         = 8'h00;
    localparam logic [FCODE_W-1:0] FC_TABLE_MISS = 8'h05;
    localparam logic [FCODE_W-1:0] FC_PAGE_MISS  = 8'h08;
    localparam logic [FCODE_W-1:0] FC_SUPER_MISS = 8'h0B;
    localparam logic [FCODE_W-1:0] FC_BAD_L1     = 8'h0C;
    localparam logic [FCODE_W-1:0] FC_BAD_L2     = 8'h0D;
    localparam logic [FCODE_W-1:0] FC_NO_READ    = 8'h11;
    localparam logic [FCODE_W-1:0] FC_NO_WRITE   = 8'h12;
    localparam logic [FCODE_W-1:0] FC_NO_EXEC    = 8'h13;

    localparam int BIT_PRESENT = 2;
    localparam int BIT_GRANT_R = 8;
    localparam int BIT_GRANT_W = 7;
    localparam int BIT_GRANT_X = 6;

    localparam logic [1:0] DT_TABLE = 2'd0;
    localparam logic [1:0] DT_SUPER = 2'd3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_RESP = 2'd3
    } walk_st_e;
endpackage

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
    import pt_walker_pkg::*;
(
    input  logic [2:0]         grant_rwx,
    input  logic [1:0]         acc,
    input  logic               is_user,
    output logic [FCODE_W-1:0] code
);
    always_comb begin
        code = FC_OK;
        if (is_user) begin
            unique case (acc)
                ACC_READ:  if (!grant_rwx[0]) code = FC_NO_READ;
                ACC_WRITE: if (!grant_rwx[1]) code = FC_NO_WRITE;
                ACC_EXEC:  if (!grant_rwx[2]) code = FC_NO_EXEC;
                default:   code = FC_OK;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker_fault_regs.sv
module pt_walker_fault_regs
    import pt_walker_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FCODE_W-1:0] code_in,
    input  logic [AW-1:0]      va_in,
    output logic [FCODE_W-1:0] status,
    output logic [AW-1:0]      addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            addr   <= '0;
        end else if (load) begin
            status <= code_in;
            addr   <= va_in;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SP_OFS = 22,
    parameter int PG_OFS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_xlate_on,
    input  logic [AW-PG_OFS-1:0] cfg_tbase,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_va,
    input  logic [1:0]         req_acc,
    input  logic               req_user,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_rvalid,
    input  logic [AW-1:0]      mem_rdata,
    output logic               rsp_valid,
    output logic [AW-1:0]      rsp_pa,
    output logic [2:0]         rsp_perm,
    output logic               rsp_super,
    output logic [FCODE_W-1:0] rsp_fcode,
    output logic               abort_instr,
    output logic               abort_data,
    output logic [FCODE_W-1:0] flt_status,
    output logic [AW-1:0]      flt_addr
);
    localparam int IDX_W = SP_OFS - PG_OFS;

    walk_st_e            state, nxt_state;
    logic [AW-1:0]       va_q;
    logic [1:0]          acc_q;
    logic                user_q;
    logic [AW-PG_OFS-1:0] tbl_q;

    logic                accept, bypass;
    logic                fin_load;
    logic [AW-1:0]       fin_pa;
    logic [2:0]          fin_perm;
    logic                fin_super;
    logic [FCODE_W-1:0]  fin_code;
    logic [2:0]          desc_rwx;
    logic [FCODE_W-1:0]  perm_code;
    logic [1:0]          desc_type;
    logic                desc_present;

    assign accept       = req_valid && (state == ST_IDLE);
    assign bypass       = !cfg_xlate_on || (!req_user && !req_va[AW-1]);
    assign desc_type    = mem_rdata[1:0];
    assign desc_present = mem_rdata[BIT_PRESENT];
    assign desc_rwx     = {mem_rdata[BIT_GRANT_X], mem_rdata[BIT_GRANT_W], mem_rdata[BIT_GRANT_R]};

    pt_walker_perm u_perm (
        .grant_rwx (desc_rwx),
        .acc       (acc_q),
        .is_user   (user_q),
        .code      (perm_code)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // next state and walk result
    always_comb begin
        nxt_state = state;
        fin_load  = 1'b0;
        fin_pa    = '0;
        fin_perm  = '0;
        fin_super = 1'b0;
        fin_code  = FC_OK;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (bypass) begin
                        nxt_state = ST_RESP;
                        fin_load  = 1'b1;
                        fin_perm  = 3'b111;
                        fin_pa    = req_va;
                        if (cfg_xlate_on) fin_pa[AW-1] = 1'b1;
                    end else begin
                        nxt_state = ST_L1;
                    end
                end
            end
            ST_L1: begin
                if (mem_rvalid) begin
                    nxt_state = ST_RESP;
                    fin_load  = 1'b1;
                    if (desc_type == DT_SUPER) begin
                        if (!desc_present)      fin_code = FC_SUPER_MISS;
                        else if (perm_code != FC_OK) fin_code = perm_code;
                        else begin
                            fin_pa    = {mem_rdata[AW-1:SP_OFS], va_q[SP_OFS-1:0]};
                            fin_perm  = desc_rwx;
                            fin_super = 1'b1;
                        end
                    end else if (desc_type == DT_TABLE) begin
                        if (!desc_present) fin_code = FC_TABLE_MISS;
                        else begin
                            nxt_state = ST_L2;
                            fin_load  = 1'b0;
                        end
                    end else begin
                        fin_code = FC_BAD_L1;
                    end
                end
            end
            ST_L2: begin
                if (mem_rvalid) begin
                    nxt_state = ST_RESP;
                    fin_load  = 1'b1;
                    if (!desc_present)                fin_code = FC_PAGE_MISS;
                    else if (desc_type != DT_TABLE)   fin_code = FC_BAD_L2;
                    else if (perm_code != FC_OK)      fin_code = perm_code;
                    else begin
                        fin_pa   = {mem_rdata[AW-1:PG_OFS], va_q[PG_OFS-1:0]};
                        fin_perm = desc_rwx;
                    end
                end
            end
            ST_RESP: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // captured request and answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            acc_q     <= '0;
            user_q    <= 1'b0;
            tbl_q     <= '0;
            rsp_pa    <= '0;
            rsp_perm  <= '0;
            rsp_super <= 1'b0;
            rsp_fcode <= '0;
        end else begin
            if (accept) begin
                va_q   <= req_va;
                acc_q  <= req_acc;
                user_q <= req_user;
            end
            if (state == ST_L1 && mem_rvalid) tbl_q <= mem_rdata[AW-1:PG_OFS];
            if (fin_load) begin
                rsp_pa    <= fin_pa;
                rsp_perm  <= fin_perm;
                rsp_super <= fin_super;
                rsp_fcode <= fin_code;
            end
        end
    end

    pt_walker_fault_regs #(.AW(AW)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fin_load && (fin_code != FC_OK)),
        .code_in (fin_code),
        .va_in   (va_q),
        .status  (flt_status),
        .addr    (flt_addr)
    );

    // outputs decoded from state
    always_comb begin
        req_ready   = (state == ST_IDLE);
        rsp_valid   = (state == ST_RESP);
        mem_req     = (state == ST_L1) || (state == ST_L2);
        mem_addr    = (state == ST_L2)
                    ? {tbl_q, va_q[SP_OFS-1:PG_OFS], 2'b00}
                    : {cfg_tbase, va_q[AW-1:SP_OFS], 2'b00};
        abort_instr = rsp_valid && (rsp_fcode != FC_OK) && (acc_q == ACC_EXEC);
        abort_data  = rsp_valid && (rsp_fcode != FC_OK) && (acc_q != ACC_EXEC);
    end

    initial begin
        if (IDX_W != 10) $display("pt_walker: unusual level split %0d", IDX_W);
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_xlate_on,
    input logic               req_valid,
    input logic               req_ready,
    input logic [31:0]        req_va,
    input logic               req_user,
    input logic               mem_req,
    input logic [31:0]        mem_addr,
    input logic               mem_rvalid,
    input logic               rsp_valid,
    input logic [2:0]         rsp_perm,
    input logic [FCODE_W-1:0] rsp_fcode,
    input logic               abort_instr,
    input logic               abort_data,
    input logic [FCODE_W-1:0] flt_status
);
    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_ready_low_in_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_resp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_bypass_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!cfg_xlate_on || (!req_user && !req_va[31]))) |=> !mem_req);

    assert_fault_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fcode != FC_OK) |-> (flt_status == rsp_fcode));

    assert_fault_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fcode != FC_OK) |-> (rsp_perm == 3'b000));

    assert_abort_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_instr || abort_data) |-> (rsp_valid && rsp_fcode != FC_OK && !(abort_instr && abort_data)));
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_xlate_on(cfg_xlate_on),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_va      (req_va),
    .req_user    (req_user),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .rsp_valid   (rsp_valid),
    .rsp_perm    (rsp_perm),
    .rsp_fcode   (rsp_fcode),
    .abort_instr (abort_instr),
    .abort_data  (abort_data),
    .flt_status  (flt_status)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_xlate_on = 1'b0;
    logic [19:0] cfg_tbase = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_perm;
    logic        rsp_super;
    logic [7:0]  rsp_fcode;
    logic        abort_instr, abort_data;
    logic [7:0]  flt_status;
    logic [31:0] flt_addr;

    int errors = 0;
    int checks = 0;
    int seen [0:255];

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .cfg_xlate_on(cfg_xlate_on), .cfg_tbase(cfg_tbase),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
        .req_user(req_user), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
        .rsp_super(rsp_super), .rsp_fcode(rsp_fcode), .abort_instr(abort_instr),
        .abort_data(abort_data), .flt_status(flt_status), .flt_addr(flt_addr)
    );

    // hashed descriptor memory
    function automatic logic [31:0] memw(input logic [31:0] a);
        logic [31:0] h, d;
        h = a ^ (a >> 13);
        h = h * 32'h2C1B3C6D;
        h = h ^ (h >> 12);
        h = h * 32'h297A2D39;
        h = h ^ (h >> 15);
        d = h;
        if (h[30:28] != 3'd0) d[1:0] = h[27:26] != 2'd0 ? 2'b00 : 2'b11;
        d[2] = (h[25:23] != 3'd0);
        return d;
    endfunction

    typedef struct packed {
        logic [31:0] pa;
        logic [2:0]  perm;
        logic        sup;
        logic [7:0]  code;
        logic        walk;
        logic [31:0] l1a;
    } exp_t;

    function automatic logic [7:0] permc(input logic [31:0] d, input logic [1:0] acc, input logic user);
        if (!user) return 8'h00;
        if (acc == 2'd0 && !d[8]) return 8'h11;
        if (acc == 2'd1 && !d[7]) return 8'h12;
        if (acc == 2'd2 && !d[6]) return 8'h13;
        return 8'h00;
    endfunction

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc,
                                   input logic user, input logic on, input logic [19:0] tb);
        exp_t e;
        logic [31:0] d, d2, l2a;
        e = '0;
        if (!on) begin e.pa = va; e.perm = 3'b111; return e; end
        if (!user && !va[31]) begin e.pa = va | 32'h8000_0000; e.perm = 3'b111; return e; end
        e.walk = 1'b1;
        e.l1a = {tb, 12'h000} | ((va >> 20) & 32'hFFC);
        d = memw(e.l1a);
        if (d[1:0] == 2'b11) begin
            if (!d[2]) e.code = 8'h0B;
            else if (permc(d, acc, user) != 0) e.code = permc(d, acc, user);
            else begin e.pa = {d[31:22], va[21:0]}; e.perm = {d[6], d[7], d[8]}; e.sup = 1'b1; end
        end else if (d[1:0] == 2'b00) begin
            if (!d[2]) e.code = 8'h05;
            else begin
                l2a = {d[31:12], 12'h000} | ((va >> 10) & 32'hFFC);
                d2 = memw(l2a);
                if (!d2[2]) e.code = 8'h08;
                else if (d2[1:0] != 2'b00) e.code = 8'h0D;
                else if (permc(d2, acc, user) != 0) e.code = permc(d2, acc, user);
                else begin e.pa = {d2[31:12], va[11:0]}; e.perm = {d2[6], d2[7], d2[8]}; end
            end
        end else e.code = 8'h0C;
        return e;
    endfunction

    // memory responder with random latency; records reads since last answer
    int unsigned lat = 0;
    int          rd_cnt = 0;
    logic [31:0] first_rd = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0; lat <= 0; rd_cnt <= 0;
        end else begin
            if (rsp_valid) rd_cnt <= 0;
            if (mem_rvalid) mem_rvalid <= 1'b0;
            else if (mem_req) begin
                if (lat == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= memw(mem_addr);
                    if (rd_cnt == 0) first_rd <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                    lat <= $urandom % 4;
                end else lat <= lat - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [7:0]  exp_fs = '0;
    logic [31:0] exp_fa = '0;

    task automatic xact(input logic [31:0] va, input logic [1:0] acc, input logic user, input logic on);
        exp_t e;
        @(negedge clk);
        cfg_xlate_on = on;
        req_va = va; req_acc = acc; req_user = user; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        e = model(va, acc, user, on, cfg_tbase);
        chk(!req_ready, "R11 ready low after accept", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid) begin
            @(negedge clk);
            if (!rsp_valid && req_ready) chk(1'b0, "R11 ready during walk", 32'd1, 32'd0);
        end
        if (e.code != 0) begin exp_fs = e.code; exp_fa = va; end
        seen[e.code]++;
        if (!on) chk(rsp_pa == e.pa && rsp_perm == 3'b111, "R1 identity", rsp_pa, e.pa);
        else if (!e.walk) chk(rsp_pa == e.pa && rsp_perm == 3'b111, "R2 io window", rsp_pa, e.pa);
        else if (e.sup) chk(rsp_pa == e.pa, "R4 superpage pa", rsp_pa, e.pa);
        else chk(rsp_pa == e.pa, "R6 page pa", rsp_pa, e.pa);
        if (!e.walk) chk(rd_cnt == 0, "R2 no descriptor read", rd_cnt, 0);
        else chk(first_rd == e.l1a, "R3 first-level address", first_rd, e.l1a);
        if (e.walk && rd_cnt == 2 && e.code != 8'h05) chk(1'b1, "R5 second read", 0, 0);
        chk(rsp_fcode == e.code, "R7 fault code", {24'd0, rsp_fcode}, {24'd0, e.code});
        chk(rsp_perm == e.perm, "R8 grant", {29'd0, rsp_perm}, {29'd0, e.perm});
        chk(rsp_super == e.sup, "R4 super flag", {31'd0, rsp_super}, {31'd0, e.sup});
        chk(flt_status == exp_fs && flt_addr == exp_fa, "R9 fault registers", flt_addr, exp_fa);
        chk(abort_instr == (e.code != 0 && acc == 2'd2) && abort_data == (e.code != 0 && acc != 2'd2),
            "R10 abort cause", {30'd0, abort_instr, abort_data},
            {30'd0, e.code != 0 && acc == 2'd2, e.code != 0 && acc != 2'd2});
        @(negedge clk);
        chk(!rsp_valid && !abort_instr && !abort_data, "R11 single answer", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned s;
        s = $urandom(32'd20240);
        for (int i = 0; i < 256; i++) seen[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R11 reset idle", {31'd0, req_ready}, 32'd1);
        chk(flt_status == 0 && flt_addr == 0, "R9 reset fault regs", flt_addr, 0);
        cfg_tbase = 20'h12345;
        // directed corners
        xact(32'h0ABC_DEF0, 2'd1, 1'b1, 1'b0);   // R1 user, off
        xact(32'hF000_0004, 2'd2, 1'b0, 1'b0);   // R1 high addr, off
        xact(32'h1234_5678, 2'd0, 1'b0, 1'b1);   // R2 privileged low half
        xact(32'h7FFF_FFFF, 2'd2, 1'b0, 1'b1);   // R2 boundary
        xact(32'h8000_0000, 2'd0, 1'b0, 1'b1);   // privileged walk
        xact(32'h0000_0000, 2'd2, 1'b1, 1'b1);   // user walk low half
        for (int n = 0; n < 700; n++) begin
            if (n % 50 == 0) cfg_tbase = 20'($urandom);
            xact($urandom, 2'($urandom % 3), 1'($urandom % 3 != 0), ($urandom % 10) != 0);
        end
        chk(seen[8'h0B] > 0, "R4 superpage miss seen", seen[8'h0B], 1);
        chk(seen[8'h05] > 0, "R5 table miss seen", seen[8'h05], 1);
        chk(seen[8'h08] > 0, "R6 page miss seen", seen[8'h08], 1);
        chk(seen[8'h0C] > 0 && seen[8'h0D] > 0, "R7 bad type seen", seen[8'h0C], 1);
        chk(seen[8'h11] > 0 && seen[8'h12] > 0 && seen[8'h13] > 0, "R8 perm faults seen", seen[8'h13], 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule